// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital control sequencer for a successive-approximation converter. It divides the system clock into a slower converter clock and starts conversions in one of three ways: a software start bit, an automatic restart after each result, or a rising edge on an external trigger line. It counts out the converter-clock cycles of each conversion, raises a sample-and-hold strobe at the right half-cycle, and writes the result into a 10-bit data register when the conversion ends. Completion raises a sticky flag.

The analog side is modelled only by a 10-bit input word. The datapath captures that word on the sample strobe and copies it to the result register at completion. After the block is enabled, the first conversion is longer because it also initialises the analog circuitry, and it samples later. Trigger-started conversions realign the divider so that the time from trigger to sample is fixed.

Top module: `adc_sequencer`

## Requirements
- R1: `prescSel` codes 0 to 7 divide the system clock by 2, 2, 4, 8, 16, 32, 64 and 128 (D below). The divider phase counter is held at zero while `enable` is low. Converter-clock rising edges fall on system cycles n = D-1, 2D-1, ..., where n counts cycles from the first cycle with `enable` high.
- R2: After reset, `startBit`, `busy`, `sampleStrobe` and `doneFlag` are 0 and `result` is 0.
- R3: The first conversion after `enable` rises lasts 25 converter cycles and strobes at 14.5 of them. With start requested in cycle 0, the strobe is seen at n = 15D + D/2 - 1 and the flag at n = 26D.
- R4: A software start pulsed in cycle m sets `startBit` from m+1. The conversion begins on the first converter edge t ≥ m+1. A normal conversion lasts 13 converter cycles, strobes at t + 1.5D, and shows the flag at t + 13D + 1.
- R5: `result` takes the `analogIn` value present in the cycle where `sampleStrobe` is high. It changes only when a conversion completes.
- R6: `modeSel` encodes 0 = single, 1 = free-running, 2 = auto-trigger and 3 = single. In single and auto modes, `startBit` and `busy` clear when the conversion completes.
- R7: In free-running mode, a new normal conversion starts on the same converter edge that ends the previous one. `startBit` stays high.
- R8: In auto mode, when idle, a rising `trigIn` edge in cycle r resets the divider phase and starts a conversion. The strobe comes at r + 3 + 2D for a normal conversion and at r + 3 + 15D for a first conversion.
- R9: `doneFlag` stays set until a cycle with `flagClear` high clears it. Completion takes priority over clearing in the same cycle.
- R10: `startSet` has no effect while `startBit` is already high or while `enable` is low.
- R11: Dropping `enable` aborts a conversion. It clears `busy` and `startBit` and leaves `result` and `doneFlag` unchanged. The next conversion is again a first conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Converter enable; low holds divider and aborts |
| modeSel | input | 2 | 0 single, 1 free-running, 2 auto-trigger, 3 single |
| prescSel | input | 3 | Divider select code |
| startSet | input | 1 | Software write of one to the start bit |
| flagClear | input | 1 | Software write of one to the completion flag |
| trigIn | input | 1 | Asynchronous trigger source for auto mode |
| analogIn | input | 10 | Stand-in for the sampled analog value |
| startBit | output | 1 | Start bit read-back |
| busy | output | 1 | A conversion is counting |
| sampleStrobe | output | 1 | Sample-and-hold strobe, one cycle |
| doneFlag | output | 1 | Sticky completion flag |
| result | output | 10 | Conversion result register |

## Verification
Single-mode conversions run at all eight divider codes. Each first conversion is followed by a normal conversion started at a different divider phase, so errors in the division ratio, in the wait for the next edge, and in the first and normal lengths show up as distinct offsets. The input word changes every cycle, so a strobe off by one cycle gives a wrong result. Free-running, auto-trigger at two divider settings, a start pulsed mid-conversion, a start while disabled, and a mid-conversion abort separate the restart, resynchronisation, ignore and abort paths.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CYC_W = 5;
  localparam int FIRST_LEN = 25;
  localparam int NORM_LEN = 13;
  localparam int FIRST_SAMPLE = 15;
  localparam int NORM_SAMPLE = 2;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_FREE   = 2'd1,
    MODE_AUTO   = 2'd2,
    MODE_SPARE  = 2'd3
  } conv_mode_t;

  typedef struct packed {
    logic sampleNow;
    logic commitNow;
  } seq_strobe_t;
endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
  parameter int SEL_W = 3,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [SEL_W-1:0] prescSel,
  input  logic             reload,
  output logic             tick,
  output logic             halfTick
);
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W:0]   divisor;
  logic [CNT_W:0]   halfVal;

  always_comb begin
    if (prescSel <= SEL_W'(1)) divisor = (CNT_W+1)'(2);
    else divisor = (CNT_W+1)'(1) << prescSel;
    halfVal = divisor >> 1;
  end

  assign tick     = enable && ({1'b0, phaseCnt} >= divisor - 1'b1);
  assign halfTick = enable && ({1'b0, phaseCnt} == halfVal - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phaseCnt <= '0;
    else if (!enable) phaseCnt <= '0;
    else if (reload) phaseCnt <= halfVal[CNT_W-1:0];
    else if (tick) phaseCnt <= '0;
    else phaseCnt <= phaseCnt + 1'b1;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int CNT_W = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       modeSel,
  input  logic [SEL_W-1:0] prescSel,
  input  logic             startSet,
  input  logic             flagClear,
  input  logic             trigIn,
  output seq_strobe_t      strobes,
  output logic             startBit,
  output logic             busy,
  output logic             doneFlag
);
  logic [SYNC_STAGES-1:0] trigSync;
  logic trigPrev, trigEvt, autoFire, tick, halfTick;
  logic firstConv, lastCyc;
  logic [CYC_W-1:0] cycCnt, convLen, samplePt;

  // two synchroniser flops plus the edge register give three cycles of delay
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trigSync <= '0;
      trigPrev <= 1'b0;
      trigEvt  <= 1'b0;
    end else begin
      trigSync <= {trigSync[SYNC_STAGES-2:0], trigIn};
      trigPrev <= trigSync[SYNC_STAGES-1];
      trigEvt  <= trigSync[SYNC_STAGES-1] && !trigPrev;
    end
  end

  assign autoFire = trigEvt && enable && (modeSel == MODE_AUTO) && !startBit;

  adc_seq_clkdiv #(.SEL_W(SEL_W), .CNT_W(CNT_W)) divider (
    .clk(clk), .rst_n(rst_n), .enable(enable), .prescSel(prescSel),
    .reload(autoFire), .tick(tick), .halfTick(halfTick)
  );

  assign convLen  = firstConv ? CYC_W'(FIRST_LEN) : CYC_W'(NORM_LEN);
  assign samplePt = firstConv ? CYC_W'(FIRST_SAMPLE) : CYC_W'(NORM_SAMPLE);
  assign lastCyc  = busy && (cycCnt == convLen);

  assign strobes.sampleNow = busy && halfTick && (cycCnt == samplePt);
  assign strobes.commitNow = tick && lastCyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      startBit  <= 1'b0;
      firstConv <= 1'b1;
      cycCnt    <= '0;
    end else if (!enable) begin
      busy      <= 1'b0;
      startBit  <= 1'b0;
      firstConv <= 1'b1;
      cycCnt    <= '0;
    end else begin
      if ((startSet && !startBit) || autoFire) startBit <= 1'b1;
      if (tick) begin
        if (lastCyc) begin
          firstConv <= 1'b0;
          if (modeSel == MODE_FREE) cycCnt <= CYC_W'(1);
          else begin
            busy     <= 1'b0;
            startBit <= 1'b0;
            cycCnt   <= '0;
          end
        end else if (busy) begin
          cycCnt <= cycCnt + 1'b1;
        end else if (startBit) begin
          busy   <= 1'b1;
          cycCnt <= CYC_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) doneFlag <= 1'b0;
    else if (strobes.commitNow) doneFlag <= 1'b1;
    else if (flagClear) doneFlag <= 1'b0;
  end
endmodule

// File: rtl/adc_seq_data.sv
module adc_seq_data
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_strobe_t       strobes,
  input  logic [DATA_W-1:0] analogIn,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] heldVal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      heldVal <= '0;
      result  <= '0;
    end else begin
      if (strobes.sampleNow) heldVal <= analogIn;
      if (strobes.commitNow) result <= heldVal;
    end
  end
endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int SEL_W  = 3,
  localparam int MAX_DIV = 1 << ((1 << SEL_W) - 1),
  localparam int CNT_W   = $clog2(MAX_DIV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        modeSel,
  input  logic [SEL_W-1:0]  prescSel,
  input  logic              startSet,
  input  logic              flagClear,
  input  logic              trigIn,
  input  logic [DATA_W-1:0] analogIn,
  output logic              startBit,
  output logic              busy,
  output logic              sampleStrobe,
  output logic              doneFlag,
  output logic [DATA_W-1:0] result
);
  seq_strobe_t strobes;

  adc_seq_ctrl #(.SEL_W(SEL_W), .CNT_W(CNT_W), .SYNC_STAGES(2)) ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .modeSel(modeSel),
    .prescSel(prescSel), .startSet(startSet), .flagClear(flagClear),
    .trigIn(trigIn), .strobes(strobes), .startBit(startBit),
    .busy(busy), .doneFlag(doneFlag)
  );

  adc_seq_data #(.DATA_W(DATA_W)) data (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .analogIn(analogIn), .result(result)
  );

  assign sampleStrobe = strobes.sampleNow;
endmodule

// File: rtl/adc_sequencer_chk.sv
module adc_sequencer_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [1:0]        modeSel,
  input logic              flagClear,
  input logic              startBit,
  input logic              busy,
  input logic              sampleStrobe,
  input logic              doneFlag,
  input logic [DATA_W-1:0] result
);
  p_strobe_in_conv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStrobe |-> busy);

  p_result_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> doneFlag);

  p_begin_needs_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> startBit);

  p_single_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $fell(busy)) |-> !startBit);

  p_free_holds_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && enable && modeSel == 2'd1) |=> startBit);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (doneFlag && !flagClear) |=> doneFlag);

  p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && !startBit));
endmodule

bind adc_sequencer adc_sequencer_chk #(.DATA_W(DATA_W)) chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .modeSel(modeSel),
  .flagClear(flagClear), .startBit(startBit), .busy(busy),
  .sampleStrobe(sampleStrobe), .doneFlag(doneFlag), .result(result)
);

// File: tb/adc_sequencer_test.sv
module adc_sequencer_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, startSet = 1'b0;
  logic flagClear = 1'b0, trigIn = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic [2:0] prescSel = 3'd0;
  logic [9:0] analogIn;
  logic startBit, busy, sampleStrobe, doneFlag;
  logic [9:0] result;
  int cycNo = 0, checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cycNo <= cycNo + 1;

  function automatic logic [9:0] fval(int c);
    return 10'((c * 37 + 11) % 1024);
  endfunction
  assign analogIn = fval(cycNo);

  adc_sequencer uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .modeSel(modeSel),
    .prescSel(prescSel), .startSet(startSet), .flagClear(flagClear),
    .trigIn(trigIn), .analogIn(analogIn), .startBit(startBit), .busy(busy),
    .sampleStrobe(sampleStrobe), .doneFlag(doneFlag), .result(result)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clearFlag();
    flagClear = 1'b1; step(); flagClear = 1'b0;
  endtask

  function automatic int nextEdge(int n, int d);
    int t = n + 1;
    while (t % d != d - 1) t++;
    return t;
  endfunction

  // watch from the current cycle until the flag is seen; againAt pulses a second start
  task automatic watch(bit useStart, bit useTrig, int againAt,
                       output int sC, output int dC, output int res);
    sC = -1; dC = -1;
    if (useStart) startSet = 1'b1;
    if (useTrig) trigIn = 1'b1;
    for (int k = 0; k < 6000 && dC < 0; k++) begin
      step();
      startSet = (k + 1 == againAt);
      if (sampleStrobe && sC < 0) sC = cycNo;
      if (doneFlag) dC = cycNo;
    end
    startSet = 1'b0;
    res = result;
  endtask

  task automatic disableFor(int n);
    enable = 1'b0; step(n);
  endtask

  initial begin
    #(PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycNo, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int e, m, d, t, sC, dC, res, oldRes;
    step(3);
    rst_n = 1'b1;
    step();
    check(startBit == 0 && busy == 0 && doneFlag == 0 && sampleStrobe == 0,
          "R2", "reset flags", {startBit, busy, doneFlag}, 0);
    check(result == 0, "R2", "reset result", result, 0);

    // R1 R3 R4 R5 R6: single mode at every divider code
    for (int sel = 0; sel < 8; sel++) begin
      d = (sel <= 1) ? 2 : (1 << sel);
      prescSel = 3'(sel); modeSel = 2'd0; enable = 1'b1;
      e = cycNo;
      watch(1, 0, -1, sC, dC, res);
      check(sC == e + 15*d + d/2 - 1, "R3", "first strobe cycle", sC - e, 15*d + d/2 - 1);
      check(dC == e + 26*d, "R3", "first done cycle", dC - e, 26*d);
      check(res == fval(sC), "R5", "first result", res, fval(sC));
      check(startBit == 0 && busy == 0, "R6", "start cleared", startBit, 0);
      clearFlag();
      step(sel + 2);
      m = cycNo;
      t = nextEdge(m - e, d);
      watch(1, 0, -1, sC, dC, res);
      check(sC == e + t + d + d/2, "R4", "normal strobe cycle", sC - e, t + d + d/2);
      check(dC == e + t + 13*d + 1, "R1", "normal done cycle", dC - e, t + 13*d + 1);
      check(res == fval(sC), "R5", "normal result", res, fval(sC));
      clearFlag();
      disableFor(2);
    end

    // R9: flag stays until cleared
    prescSel = 3'd1; enable = 1'b1;
    watch(1, 0, -1, sC, dC, res);
    step(40);
    check(doneFlag == 1, "R9", "flag held", doneFlag, 1);
    clearFlag();
    check(doneFlag == 0, "R9", "flag cleared", doneFlag, 1'b0);

    // R10: start during a conversion is ignored
    m = cycNo; e = m - nextEdge(0, 2);
    watch(1, 0, 6, sC, dC, res);
    check(startBit == 0 && busy == 0, "R10", "no restart after done", busy, 0);
    t = 0;
    for (int k = 0; k < 40; k++) begin step(); if (busy || sampleStrobe) t++; end
    check(t == 0, "R10", "idle after busy start", t, 0);
    clearFlag();
    oldRes = result;

    // R10: start while disabled is ignored
    disableFor(2);
    startSet = 1'b1; step(); startSet = 1'b0; step();
    check(startBit == 0 && busy == 0, "R10", "start while disabled", startBit, 0);

    // R11: abort mid-conversion, then first-length again
    d = 4; prescSel = 3'd2; enable = 1'b1;
    startSet = 1'b1; step(); startSet = 1'b0;
    step(40);
    check(busy == 1, "R11", "running before abort", busy, 1);
    enable = 1'b0; step();
    check(busy == 0 && startBit == 0, "R11", "abort clears", {busy, startBit}, 0);
    check(result == oldRes && doneFlag == 0, "R11", "result kept", result, oldRes);
    step(3);
    enable = 1'b1; e = cycNo;
    watch(1, 0, -1, sC, dC, res);
    check(dC == e + 26*d, "R11", "first length after abort", dC - e, 26*d);
    clearFlag();
    disableFor(2);

    // R7: free-running
    modeSel = 2'd1; enable = 1'b1; e = cycNo;
    watch(1, 0, -1, sC, dC, res);
    check(dC == e + 26*d, "R7", "free first done", dC - e, 26*d);
    flagClear = 1'b1;
    watch(0, 0, -1, sC, dC, res);
    flagClear = 1'b0;
    check(sC == e + 26*d - 1 + d + d/2, "R7", "free restart strobe", sC - e, 26*d - 1 + d + d/2);
    check(dC == e + 39*d, "R7", "free second done", dC - e, 39*d);
    check(res == fval(sC), "R7", "free second result", res, fval(sC));
    check(startBit == 1 && busy == 1, "R7", "start stays high", startBit, 1);
    modeSel = 2'd0;
    step(14*d);
    check(busy == 0 && startBit == 0, "R6", "stop after leaving free", busy, 0);
    clearFlag();
    disableFor(2);

    // R8: auto trigger at two divider settings
    for (int pass = 0; pass < 2; pass++) begin
      d = (pass == 0) ? 8 : 2;
      prescSel = (pass == 0) ? 3'd3 : 3'd0;
      modeSel = 2'd2; trigIn = 1'b0; enable = 1'b1;
      step(5 + pass);
      m = cycNo;
      watch(0, 1, -1, sC, dC, res);
      check(sC == m + 3 + 15*d, "R8", "trigger first strobe", sC - m, 3 + 15*d);
      check(dC == m + 4 + 25*d + d/2, "R8", "trigger first done", dC - m, 4 + 25*d + d/2);
      check(startBit == 0, "R6", "auto clears start", startBit, 0);
      trigIn = 1'b0; clearFlag(); step(7);
      m = cycNo;
      watch(0, 1, -1, sC, dC, res);
      check(sC == m + 3 + 2*d, "R8", "trigger normal strobe", sC - m, 3 + 2*d);
      check(dC == m + 4 + 13*d + d/2, "R8", "trigger normal done", dC - m, 4 + 13*d + d/2);
      check(res == fval(sC), "R5", "trigger result", res, fval(sC));
      trigIn = 1'b0; clearFlag();
      disableFor(2);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule